// File: doc/BRIEF.md
# Slave-Serial FPGA Configuration Loader

This block loads a target FPGA through its slave-serial configuration port. It takes a byte stream from a host or a local memory and converts it into a bit stream on a data pin, clocked by a configuration clock that the block generates itself. When a start command arrives, the block holds the active-low program line released for a settle time. It then pulses the line low to clear the target and waits for the target to raise its INIT handshake line. After that it shifts every byte out, most-significant bit first.

Once the last byte has been sent, the block issues a few more configuration clocks so that the target can finish its startup. It then waits, with a time limit, for the target's DONE line and reports either success or failure. If INIT drops while data is being streamed, the load is aborted at once. The byte input uses a valid/ready handshake, and the block applies back-pressure on it. `s_ready` is high only while no byte is held and the block is streaming. A byte is taken in a cycle where `s_valid` and `s_ready` are both high. `s_data` and `s_last` must stay stable while `s_valid` waits for `s_ready`. The upstream side may leave gaps of any length between bytes; during a gap the configuration clock stays low.

Top module: `cfg_serial_loader`

## Requirements
- R1: On a start command seen in the idle, pass or fail state, the program line stays high for SETTLE_CYCLES clocks and is then driven low for PULSE_CYCLES clocks.
- R2: After the pulse, the program line is released and the block waits for INIT high. If INIT is still low after INIT_TIMEOUT clocks, the block enters the fail state without emitting any configuration clock.
- R3: Each bit is a low phase of HALF_PERIOD clocks, with the bit on the data pin, followed by a high phase of HALF_PERIOD clocks with the data pin stable. Bytes are sent bit 7 first.
- R4: The program line is high whenever the configuration clock is high.
- R5: `s_ready` rises only after the eighth bit of the held byte has finished its high phase. Every accepted byte is sent exactly once and in order, and no configuration clock runs while the block waits for a byte.
- R6: After the byte flagged by `s_last`, exactly STARTUP_CLKS further clock pulses are sent, with the data pin high.
- R7: After the startup pulses, DONE high moves the block to pass (`cfg_ok`=1). If DONE stays low for DONE_TIMEOUT clocks, the block moves to fail (`cfg_err`=1).
- R8: INIT low while streaming (bytes or startup pulses) moves the block to fail on the next clock. This takes priority over a byte handshake in the same cycle, and no further clock pulse follows.
- R9: In the idle, pass and fail states `busy` is 0, the configuration clock is low and the program line is high. Pass and fail hold until the next start, and a start while busy has no effect.
- R10: After reset: idle, program line high, configuration clock low, `busy`, `cfg_ok`, `cfg_err` and `s_ready` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a configuration cycle (one-clock pulse) |
| s_data | input | 8 | Configuration byte |
| s_valid | input | 1 | s_data holds a byte |
| s_last | input | 1 | This byte ends the stream |
| s_ready | output | 1 | Block takes the byte this cycle if s_valid |
| prog_n | output | 1 | Active-low program/clear line to the target |
| cclk | output | 1 | Generated configuration clock |
| din | output | 1 | Serial configuration data |
| init_i | input | 1 | Target INIT handshake (high = ready) |
| done_i | input | 1 | Target DONE indication |
| busy | output | 1 | A configuration cycle is running |
| cfg_ok | output | 1 | Last cycle ended in success |
| cfg_err | output | 1 | Last cycle ended in failure |

## Verification
The case where two functions meet in one cycle is INIT falling at the same clock edge at which a byte handshake completes. In that cycle the stream engine would latch the byte while the sequencer aborts. The bench waits at a falling edge until `s_ready` is high with `s_valid` asserted, and in that same instant pulls INIT low. It then expects `cfg_err` one cycle later, the configuration clock low, and no pulse counted beyond the bytes already finished. Randomised runs also vary byte gaps, INIT delay and DONE level. A start pulse is injected mid-stream to show that it is ignored.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_SETTLE, S_CLEAR, S_WAIT_INIT, S_STREAM, S_DONE_WAIT, S_PASS, S_FAIL
  } cfg_state_e;

  function automatic int cfgl_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/cfgl_countdown.sv
module cfgl_countdown #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/cfgl_bit_engine.sv
module cfgl_bit_engine #(
  parameter int HALF_PERIOD  = 2,
  parameter int STARTUP_CLKS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       s_valid,
  input  logic [7:0] s_data,
  input  logic       s_last,
  output logic       s_ready,
  output logic       cclk,
  output logic       din,
  output logic       fin
);
  localparam int HW = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
  localparam logic [HW-1:0] HLAST = HW'(HALF_PERIOD - 1);
  localparam int PW = (STARTUP_CLKS > 1) ? $clog2(STARTUP_CLKS) : 1;
  localparam logic [PW-1:0] PLAST = PW'((STARTUP_CLKS > 0) ? STARTUP_CLKS - 1 : 0);

  logic          loaded, pad_mode, fin_q, is_last, ph;
  logic [7:0]    sh;
  logic [2:0]    bidx;
  logic [HW-1:0] hcnt;
  logic [PW-1:0] pcnt;
  logic          act, half_end, bit_end, take;

  // a pulse runs while a byte is held or startup pulses remain
  assign act      = loaded | (pad_mode & ~fin_q);
  assign half_end = act && (hcnt == HLAST);
  assign bit_end  = half_end & ph;
  assign s_ready  = en & ~loaded & ~pad_mode & ~fin_q;
  assign take     = s_valid & s_ready;
  assign cclk     = en & act & ph;
  assign din      = pad_mode ? 1'b1 : sh[7];
  assign fin      = fin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded <= 1'b0; pad_mode <= 1'b0; fin_q <= 1'b0; is_last <= 1'b0; ph <= 1'b0;
      sh <= '0; bidx <= '0; hcnt <= '0; pcnt <= '0;
    end else if (!en) begin
      loaded <= 1'b0; pad_mode <= 1'b0; fin_q <= 1'b0; is_last <= 1'b0; ph <= 1'b0;
      sh <= '0; bidx <= '0; hcnt <= '0; pcnt <= '0;
    end else begin
      if (half_end) begin
        hcnt <= '0;
        ph   <= ~ph;
      end else if (act) begin
        hcnt <= hcnt + 1'b1;
      end else begin
        hcnt <= '0;
        ph   <= 1'b0;
      end

      if (take) begin
        sh      <= s_data;
        loaded  <= 1'b1;
        bidx    <= '0;
        is_last <= s_last;
      end else if (loaded && bit_end) begin
        if (bidx == 3'd7) begin
          loaded <= 1'b0;
          if (is_last) begin
            pad_mode <= 1'b1;
            if (STARTUP_CLKS == 0) fin_q <= 1'b1;
          end
        end else begin
          bidx <= bidx + 1'b1;
          sh   <= {sh[6:0], 1'b0};
        end
      end

      if (pad_mode && bit_end) begin
        pcnt <= pcnt + 1'b1;
        if (pcnt == PLAST) fin_q <= 1'b1;
      end
    end
  end

  // R3: data pin holds while the clock stays high
  p_din_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cclk && $past(cclk)) |-> $stable(din));

  // R5: no clock pulse while a new byte is being requested
  p_ready_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> !cclk);

  // R6: startup pulses carry a high data pin
  p_pad_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cclk && pad_mode) |-> din);
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
  import cfgl_pkg::*;
#(
  parameter int HALF_PERIOD   = 2,
  parameter int SETTLE_CYCLES = 40000,
  parameter int PULSE_CYCLES  = 50,
  parameter int INIT_TIMEOUT  = 100000,
  parameter int DONE_TIMEOUT  = 100000,
  parameter int STARTUP_CLKS  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] s_data,
  input  logic       s_valid,
  input  logic       s_last,
  output logic       s_ready,
  output logic       prog_n,
  output logic       cclk,
  output logic       din,
  input  logic       init_i,
  input  logic       done_i,
  output logic       busy,
  output logic       cfg_ok,
  output logic       cfg_err
);
  localparam int TMAX = cfgl_max(cfgl_max(SETTLE_CYCLES, PULSE_CYCLES),
                                 cfgl_max(INIT_TIMEOUT, DONE_TIMEOUT));
  localparam int TW = $clog2(TMAX + 1);
  localparam logic [TW-1:0] T_SETTLE = TW'(SETTLE_CYCLES - 1);
  localparam logic [TW-1:0] T_PULSE  = TW'(PULSE_CYCLES - 1);
  localparam logic [TW-1:0] T_INIT   = TW'(INIT_TIMEOUT - 1);
  localparam logic [TW-1:0] T_DONE   = TW'(DONE_TIMEOUT - 1);

  cfg_state_e    st, nx;
  logic          tload, tzero, eng_en, eng_fin;
  logic [TW-1:0] tval;

  cfgl_countdown #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tload), .val(tval), .zero(tzero)
  );

  assign eng_en = (st == S_STREAM);

  cfgl_bit_engine #(.HALF_PERIOD(HALF_PERIOD), .STARTUP_CLKS(STARTUP_CLKS)) u_engine (
    .clk(clk), .rst_n(rst_n), .en(eng_en),
    .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
    .cclk(cclk), .din(din), .fin(eng_fin)
  );

  always_comb begin
    nx    = st;
    tload = 1'b0;
    tval  = '0;
    unique case (st)
      S_IDLE, S_PASS, S_FAIL:
        if (start) begin nx = S_SETTLE; tload = 1'b1; tval = T_SETTLE; end
      S_SETTLE:
        if (tzero) begin nx = S_CLEAR; tload = 1'b1; tval = T_PULSE; end
      S_CLEAR:
        if (tzero) begin nx = S_WAIT_INIT; tload = 1'b1; tval = T_INIT; end
      S_WAIT_INIT:
        if (init_i)     nx = S_STREAM;
        else if (tzero) nx = S_FAIL;
      S_STREAM:
        if (!init_i)       nx = S_FAIL;
        else if (eng_fin) begin nx = S_DONE_WAIT; tload = 1'b1; tval = T_DONE; end
      S_DONE_WAIT:
        if (done_i)     nx = S_PASS;
        else if (tzero) nx = S_FAIL;
      default: nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= S_IDLE;
    else        st <= nx;
  end

  assign prog_n  = (st != S_CLEAR);
  assign busy    = (st != S_IDLE) && (st != S_PASS) && (st != S_FAIL);
  assign cfg_ok  = (st == S_PASS);
  assign cfg_err = (st == S_FAIL);

  // R4: the program line is released whenever a clock pulse is out
  p_prog_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cclk |-> prog_n);

  // R8: INIT low during streaming leads to fail next cycle
  p_init_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_en && !init_i) |=> (cfg_err && !cclk));

  // R9: quiet outputs whenever not busy
  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!cclk && prog_n && !s_ready));

  // R7: pass only follows a DONE seen high
  p_pass_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_ok) |-> $past(done_i));

  // R2: streaming only begins with INIT high
  p_stream_init_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_en) |-> $past(init_i));
endmodule

// File: tb/cfg_serial_loader_test.sv
module cfg_serial_loader_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF   = 2;
  localparam int SETTLE = 20;
  localparam int PULSE  = 5;
  localparam int ITMO   = 40;
  localparam int DTMO   = 30;
  localparam int PAD    = 3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] s_data = '0;
  logic s_valid = 1'b0, s_last = 1'b0;
  logic s_ready, prog_n, cclk, din, init_i, done_i, busy, cfg_ok, cfg_err;

  int total = 0, bad = 0;
  int nbits = 0, hi_run = 0, hi_bad = 0;
  bit cap [0:511];
  logic [7:0] tx [0:15];

  // target model
  logic init_drv;
  int   icnt;
  int   init_delay = 3;
  bit   init_never = 1'b0, init_kill = 1'b0, done_lvl = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_serial_loader #(
    .HALF_PERIOD(HALF), .SETTLE_CYCLES(SETTLE), .PULSE_CYCLES(PULSE),
    .INIT_TIMEOUT(ITMO), .DONE_TIMEOUT(DTMO), .STARTUP_CLKS(PAD)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .s_data(s_data), .s_valid(s_valid),
    .s_last(s_last), .s_ready(s_ready), .prog_n(prog_n), .cclk(cclk), .din(din),
    .init_i(init_i), .done_i(done_i), .busy(busy), .cfg_ok(cfg_ok), .cfg_err(cfg_err)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin init_drv <= 1'b1; icnt <= 0; end
    else if (!prog_n) begin init_drv <= 1'b0; icnt <= 0; end
    else if (!init_drv && !init_never) begin
      if (icnt >= init_delay) init_drv <= 1'b1;
      else icnt <= icnt + 1;
    end
  end
  assign init_i = init_drv && !init_kill;
  assign done_i = done_lvl;

  always @(posedge cclk) begin
    if (nbits < 512) cap[nbits] = din;
    nbits = nbits + 1;
  end

  always @(negedge clk) begin
    if (cclk) hi_run = hi_run + 1;
    else if (hi_run != 0) begin
      if (hi_run != HALF) hi_bad = hi_bad + 1;
      hi_run = 0;
    end
  end

  function automatic bit exp_bit(input logic [7:0] b, input int idx);
    return b[7 - idx];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_idle();
    int c = 0;
    while (busy && c < 5000) begin @(negedge clk); c++; end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic prep(input int idly, input bit dval);
    init_kill = 1'b0; init_never = 1'b0; init_delay = idly; done_lvl = dval;
    nbits = 0; hi_bad = 0;
  endtask

  // full load; poke issues a start pulse mid-stream
  task automatic run_load(input int n, input int idly, input bit dval, input bit poke);
    int waits, lowc, mism, pad_bad;
    prep(idly, dval);
    for (int i = 0; i < n; i++) tx[i] = 8'($urandom);
    pulse_start();
    waits = 1;
    while (prog_n && waits < 1000) begin @(negedge clk); waits++; end
    chk(waits == SETTLE + 1, "R1 settle", waits, SETTLE + 1);
    lowc = 0;
    while (!prog_n && lowc < 1000) begin @(negedge clk); lowc++; end
    chk(lowc == PULSE, "R1 pulse", lowc, PULSE);
    for (int i = 0; i < n; i++) begin
      repeat ($urandom % 3) @(negedge clk);
      s_valid = 1'b1; s_data = tx[i]; s_last = (i == n - 1);
      while (!s_ready) @(negedge clk);
      if (poke && i == 0) start = 1'b1;
      @(negedge clk);
      start = 1'b0; s_valid = 1'b0; s_last = 1'b0;
    end
    wait_idle();
    chk(cfg_ok == dval, "R7 ok", int'(cfg_ok), int'(dval));
    chk(cfg_err == !dval, "R7 err", int'(cfg_err), int'(!dval));
    chk(nbits == 8 * n + PAD, "R6 pulse count", nbits, 8 * n + PAD);
    mism = 0;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++)
        if (cap[8 * i + b] != exp_bit(tx[i], b)) mism++;
    chk(mism == 0, "R3/R5 bit order", mism, 0);
    pad_bad = 0;
    for (int k = 0; k < PAD; k++) if (cap[8 * n + k] != 1'b1) pad_bad++;
    chk(pad_bad == 0, "R6 pad data", pad_bad, 0);
    chk(hi_bad == 0, "R3 high width", hi_bad, 0);
    repeat (10) @(negedge clk);
    chk(cfg_ok == dval && prog_n && !cclk && !busy, "R9 hold", int'(cfg_ok), int'(dval));
  endtask

  initial begin
    int c, base;
    void'($urandom(32'd4021));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(prog_n == 1'b1, "R10 prog_n", int'(prog_n), 1);
    chk(cclk == 1'b0, "R10 cclk", int'(cclk), 0);
    chk(busy == 1'b0, "R10 busy", int'(busy), 0);
    chk(!cfg_ok && !cfg_err, "R10 status", int'({cfg_ok, cfg_err}), 0);
    chk(s_ready == 1'b0, "R10 s_ready", int'(s_ready), 0);

    // R9: without start nothing happens
    repeat (30) @(negedge clk);
    chk(!busy && nbits == 0, "R9 no start", nbits, 0);

    // random loads
    for (int r = 0; r < 6; r++) run_load(1 + ($urandom % 6), $urandom % 8, 1'b1, 1'b0);
    // R9: start while busy ignored
    run_load(4, 2, 1'b1, 1'b1);
    // R7: DONE stays low
    run_load(2, 1, 1'b0, 1'b0);

    // R2: INIT never rises
    prep(0, 1'b1);
    init_never = 1'b1;
    pulse_start();
    c = 1;
    while (busy && c < 2000) begin @(negedge clk); c++; end
    chk(c == 1 + SETTLE + PULSE + ITMO, "R2 timeout cycles", c, 1 + SETTLE + PULSE + ITMO);
    chk(cfg_err == 1'b1, "R2 timeout err", int'(cfg_err), 1);
    chk(nbits == 0, "R2 no clock", nbits, 0);

    // R8: INIT drops in the same cycle as a byte handshake
    prep(2, 1'b1);
    for (int i = 0; i < 3; i++) tx[i] = 8'($urandom);
    pulse_start();
    for (int i = 0; i < 2; i++) begin
      s_valid = 1'b1; s_data = tx[i]; s_last = 1'b0;
      while (!s_ready) @(negedge clk);
      @(negedge clk);
      s_valid = 1'b0;
    end
    s_valid = 1'b1; s_data = tx[2];
    while (!s_ready) @(negedge clk);
    base = nbits;
    init_kill = 1'b1;
    @(negedge clk);
    s_valid = 1'b0;
    chk(cfg_err == 1'b1, "R8 abort err", int'(cfg_err), 1);
    chk(cclk == 1'b0 && !busy, "R8 clock stopped", int'(cclk), 0);
    repeat (20) @(negedge clk);
    chk(nbits == base && base == 16, "R8 no extra pulse", nbits, 16);

    // R1/R9: a start from the fail state begins a fresh load
    run_load(3, 0, 1'b1, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule